// File: doc/BRIEF.md
# SMBus Client Register Port

This block is an SMBus 2.0 client. It lets a host reach an 8-bit register file inside the chip through one fixed 7-bit bus address. The block oversamples SCL and SDA with the system clock and decodes START and STOP conditions. It acknowledges the bytes addressed to it and keeps a register pointer that persists across transactions. Writes to the register file appear as a one-cycle strobe with a pointer and a data byte. Read data comes back combinationally on an input bus indexed by the same pointer.

Four register protocols are accepted:
- Write Byte: pointer, then data.
- Read Byte: pointer, repeated START, then one data byte out.
- Send Byte: pointer only.
- Receive Byte: one data byte out at the stored pointer.

While an external alert is pending, the block also answers a read at the Alert Response Address by sending its own address byte. During that reply it checks for arbitration loss. It raises a one-cycle mask pulse only when the whole byte went out uncontested. The pulse lets surrounding logic clear the alert line.

The block never drives SCL. When the bus stays idle for a parameterised number of clock cycles in mid-transaction, the interface returns to idle and releases SDA.

Top module: `smb_client`

## Requirements
- R1: An address byte whose upper seven bits equal 0x2E (write byte 0x5C, read byte 0x5D) is acknowledged. Any other address byte, apart from the case in R7, gets no ACK. The rest of that transaction causes no write and leaves the pointer unchanged.
- R2: Write Byte (address byte 0x5C, pointer byte P, data byte D) acknowledges all three bytes. It produces exactly one single-cycle write strobe with reg_addr_o = P and reg_wdata_o = D, and sda_oe_o is high during that strobe.
- R3: Send Byte (address byte 0x5C, pointer byte P, STOP) loads P into the pointer, which appears on reg_addr_o, and causes no write.
- R4: Receive Byte (address byte 0x5D) returns the register at the current pointer, MSB first. Repeated Receive Bytes return the same register.
- R5: Read Byte (0x5C, P, repeated START, 0x5D) returns the register at P.
- R6: The pointer keeps its value across STOP. After a Write Byte it stays at the written register, and it does not move while a write strobe is active.
- R7: While alert_pend_i is high, a read at address 0x0C (address byte 0x19) is acknowledged and answered with byte 0x5C. While alert_pend_i is low, that byte gets no ACK.
- R8: mask_set_o pulses for one cycle after the eighth bit of an uncontested Alert Response reply, with SDA released. If SDA reads 0 while the block sends a 1, the block releases SDA for the rest of the byte and no pulse occurs.
- R9: A data byte beyond the one Write Byte data byte gets no ACK and causes no write.
- R10: With the interface mid-transaction and no SCL or SDA edge for TIMEOUT_CYC clock cycles, the block returns to idle and releases SDA. Before that time it holds its state.
- R11: The block asserts its SDA drive only while SCL is low, and it has no SCL output.
- R12: After reset, sda_oe_o, reg_we_o and mask_set_o are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| alert_pend_i | input | 1 | An alert is pending and not yet masked |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_addr_o | output | 8 | Register pointer, used for writes and reads |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |
| mask_set_o | output | 1 | Pulse requesting the alert mask be set |

## Verification
The bench goes after three places where things can go wrong.

The first is pointer persistence. A Send Byte followed by two Receive Bytes, and a Write Byte followed by a Receive Byte, would return the wrong register if the pointer were cleared at STOP or updated only on writes.

The second is the Alert Response reply. It is run with no alert pending, uncontested, and against a contender that pulls SDA low on the second bit. A design that ignored arbitration would corrupt the contender's later bits and still pulse the mask.

The third is the edge of the protocol. Foreign addresses, a surplus data byte and a stalled bus would show up as stray writes, a moved pointer, a spurious ACK, or an ACK held forever.

// File: rtl/smb_client_pkg.sv
package smb_client_pkg;
  localparam int BYTE_W = 8;
  localparam int BITCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_WAIT
  } smb_state_e;
endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic activity
);
  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic scl_d;
  logic sda_d;
  logic scl_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_now   = scl_sh[SYNC_STAGES-1];
  assign sda_q     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign start_det = scl_now & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_now & scl_d & ~sda_d & sda_q;
  assign activity  = (scl_now ^ scl_d) | (sda_q ^ sda_d);
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int TIMEOUT_CYC = 1_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic activity,
  output logic expire
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy || activity) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = busy && !activity && (cnt == LAST);
endmodule

// File: rtl/smb_ctrl_fsm.sv
module smb_ctrl_fsm
  import smb_client_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2E,
  parameter logic [6:0] ARA_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              timeout,
  input  logic              alert_pend,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_oe,
  output logic              we,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wdata,
  output logic              mask_set,
  output logic              busy
);
  localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

  smb_state_e           state;
  logic [BYTE_W-1:0]    shreg;
  logic [BYTE_W-1:0]    txbyte;
  logic [BITCNT_W-1:0]  bitcnt;
  logic                 tx_next;
  logic                 is_ara;
  logic                 addr_hit;
  logic                 ara_hit;

  assign addr_hit = (shreg[BYTE_W-1:1] == DEV_ADDR);
  assign ara_hit  = (shreg[BYTE_W-1:1] == ARA_ADDR) && shreg[0] && alert_pend;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      txbyte   <= '0;
      bitcnt   <= '0;
      tx_next  <= 1'b0;
      is_ara   <= 1'b0;
      sda_oe   <= 1'b0;
      we       <= 1'b0;
      ptr      <= '0;
      wdata    <= '0;
      mask_set <= 1'b0;
    end else begin
      we       <= 1'b0;
      mask_set <= 1'b0;
      if (stop_det || timeout) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        is_ara <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_q};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe  <= 1'b1;
                  tx_next <= shreg[0];
                  txbyte  <= rdata;
                  is_ara  <= 1'b0;
                  state   <= ST_ADDR_ACK;
                end else if (ara_hit) begin
                  sda_oe  <= 1'b1;
                  tx_next <= 1'b1;
                  txbyte  <= {DEV_ADDR, 1'b0};
                  is_ara  <= 1'b1;
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_CMD) begin
                ptr    <= shreg;
                sda_oe <= 1'b1;
                state  <= ST_CMD_ACK;
              end else begin
                wdata  <= shreg;
                we     <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (tx_next) begin
                sda_oe <= ~txbyte[BYTE_W-1];
                txbyte <= {txbyte[BYTE_W-2:0], 1'b0};
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_DATA;
            end
          end
          ST_DATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WAIT;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
              if (is_ara && !sda_oe && !sda_q) begin
                sda_oe <= 1'b0;
                state  <= ST_WAIT;
              end
            end else if (scl_fall) begin
              if (bitcnt == FULL) begin
                sda_oe   <= 1'b0;
                mask_set <= is_ara;
                state    <= ST_WAIT;
              end else begin
                sda_oe <= ~txbyte[BYTE_W-1];
                txbyte <= {txbyte[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_WAIT: begin
            sda_oe <= 1'b0;
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_client.sv
module smb_client #(
  parameter logic [6:0] DEV_ADDR    = 7'h2E,
  parameter logic [6:0] ARA_ADDR    = 7'h0C,
  parameter int         SYNC_STAGES = 2,
  parameter int         TIMEOUT_CYC = 1_500_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       alert_pend_i,
  output logic       reg_we_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i,
  output logic       mask_set_o
);
  logic sda_q;
  logic scl_rise;
  logic scl_fall;
  logic start_det;
  logic stop_det;
  logic activity;
  logic busy;
  logic expire;

  smb_bus_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .activity  (activity)
  );

  smb_idle_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .activity (activity),
    .expire   (expire)
  );

  smb_ctrl_fsm #(
    .DEV_ADDR(DEV_ADDR),
    .ARA_ADDR(ARA_ADDR)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .sda_q      (sda_q),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .timeout    (expire),
    .alert_pend (alert_pend_i),
    .rdata      (reg_rdata_i),
    .sda_oe     (sda_oe_o),
    .we         (reg_we_o),
    .ptr        (reg_addr_o),
    .wdata      (reg_wdata_o),
    .mask_set   (mask_set_o),
    .busy       (busy)
  );
endmodule

// File: rtl/smb_client_chk.sv
module smb_client_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       reg_we_o,
  input logic [7:0] reg_addr_o,
  input logic       mask_set_o
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sda_oe_o && !reg_we_o && !mask_set_o)); // R12

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i); // R11

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |=> !reg_we_o); // R2

  AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |-> sda_oe_o); // R2

  AST_PTR_HELD: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |=> $stable(reg_addr_o)); // R6

  AST_MASK_PULSE: assert property (@(posedge clk) disable iff (rst)
    mask_set_o |=> !mask_set_o); // R8

  AST_MASK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    mask_set_o |-> !sda_oe_o); // R8
endmodule

bind smb_client smb_client_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o),
  .mask_set_o (mask_set_o)
);

// File: tb/smb_client_tb_top.sv
module smb_client_tb_top;
  localparam int TMO = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_other = 1'b1;
  logic alert = 1'b0;
  logic sda_oe, we, mask;
  logic [7:0] raddr, wdata, rdata;
  wire  sda_line = sda_h & sda_other & ~sda_oe;

  smb_client #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_h),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .alert_pend_i (alert),
    .reg_we_o     (we),
    .reg_addr_o   (raddr),
    .reg_wdata_o  (wdata),
    .reg_rdata_i  (rdata),
    .mask_set_o   (mask)
  );

  logic [7:0] regs [256];
  initial for (int i = 0; i < 256; i++) regs[i] = 8'(i ^ 8'h5A);
  assign rdata = regs[raddr];
  always @(posedge clk) if (we) regs[raddr] <= wdata;

  int checks = 0;
  int errors = 0;
  int mask_cnt = 0;
  logic [15:0] exp_q[$];
  logic [15:0] exp_item;

  // scoreboard monitor: every write strobe must match the next expected item
  always @(negedge clk) begin
    if (mask) mask_cnt++;
    if (we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected write actual %h:%h expected none", raddr, wdata);
      end else begin
        exp_item = exp_q.pop_front();
        if ({raddr, wdata} !== exp_item) begin
          errors++;
          $display("FAIL R2 write actual %h expected %h", {raddr, wdata}, exp_item);
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hp;
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_h = 1'b1; hp; scl_h = 1'b1; hp; sda_h = 1'b0; hp; scl_h = 1'b0; hp;
  endtask

  task automatic bus_stop;
    sda_h = 1'b0; hp; scl_h = 1'b1; hp; sda_h = 1'b1; hp;
  endtask

  task automatic wbit(input logic b);
    sda_h = b; hp; scl_h = 1'b1; hp; scl_h = 1'b0; hp;
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    sda_h = 1'b1; hp; scl_h = 1'b1; hp;
    ack = ~sda_line;
    scl_h = 1'b0; hp;
  endtask

  task automatic recv(output logic [7:0] b, input logic [7:0] other);
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1'b1; sda_other = other[i]; hp;
      scl_h = 1'b1; hp;
      b[i] = sda_line;
      scl_h = 1'b0; hp;
    end
    sda_other = 1'b1;
    wbit(1'b1);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hp;
    check("R12 sda_oe after reset", int'(sda_oe), 0);
    check("R12 pointer after reset", int'(raddr), 0);
    check("R12 strobes after reset", int'({we, mask}), 0);

    // R2 Write Byte 0x35 <- 0xA7
    bus_start;
    send(8'h5C, ack); check("R1 own address ack", int'(ack), 1);
    send(8'h35, ack); check("R2 pointer byte ack", int'(ack), 1);
    exp_q.push_back({8'h35, 8'hA7});
    send(8'hA7, ack); check("R2 data byte ack", int'(ack), 1);
    bus_stop; hp;
    check("R2 write consumed", exp_q.size(), 0);
    check("R6 pointer after write", int'(raddr), 8'h35);

    // R4 Receive Byte at persistent pointer
    bus_start;
    send(8'h5D, ack); check("R4 read address ack", int'(ack), 1);
    recv(b, 8'hFF); bus_stop;
    check("R4 receive byte data", int'(b), 8'hA7);

    // Write 0x80 <- 0x3C, then R5 Read Byte of 0x35
    bus_start; send(8'h5C, ack); send(8'h80, ack);
    exp_q.push_back({8'h80, 8'h3C});
    send(8'h3C, ack); bus_stop;
    bus_start; send(8'h5C, ack); send(8'h35, ack);
    bus_start; send(8'h5D, ack); check("R5 repeated start address ack", int'(ack), 1);
    recv(b, 8'hFF); bus_stop;
    check("R5 read byte data", int'(b), 8'hA7);

    // R3 Send Byte then repeated Receive Bytes
    bus_start; send(8'h5C, ack); send(8'h80, ack); bus_stop; hp;
    check("R3 pointer loaded", int'(raddr), 8'h80);
    bus_start; send(8'h5D, ack); recv(b, 8'hFF); bus_stop;
    check("R4 first receive", int'(b), 8'h3C);
    bus_start; send(8'h5D, ack); recv(b, 8'hFF); bus_stop;
    check("R4 second receive", int'(b), 8'h3C);

    // R1 foreign addresses
    bus_start; send(8'h5E, ack); check("R1 foreign write no ack", int'(ack), 0);
    send(8'h11, ack); send(8'h22, ack); bus_stop; hp;
    check("R1 pointer unchanged", int'(raddr), 8'h80);
    bus_start; send(8'h5F, ack); check("R1 foreign read no ack", int'(ack), 0);
    bus_stop;

    // R9 surplus data byte
    bus_start; send(8'h5C, ack); send(8'h10, ack);
    exp_q.push_back({8'h10, 8'h55});
    send(8'h55, ack);
    send(8'h66, ack); check("R9 surplus byte no ack", int'(ack), 0);
    bus_stop; hp;
    check("R9 single write", exp_q.size(), 0);
    bus_start; send(8'h5D, ack); recv(b, 8'hFF); bus_stop;
    check("R9 register kept", int'(b), 8'h55);

    // R7 alert response without pending alert
    base = mask_cnt;
    bus_start; send(8'h19, ack); check("R7 no alert no ack", int'(ack), 0);
    bus_stop; hp;
    check("R7 no mask without alert", mask_cnt - base, 0);

    // R7 / R8 uncontested reply
    alert = 1'b1;
    bus_start; send(8'h19, ack); check("R7 alert address ack", int'(ack), 1);
    recv(b, 8'hFF); bus_stop; hp;
    check("R7 reply byte", int'(b), 8'h5C);
    check("R8 mask pulse once", mask_cnt - base, 1);

    // R8 contention on second bit
    base = mask_cnt;
    bus_start; send(8'h19, ack);
    recv(b, 8'h10); bus_stop; hp;
    check("R8 lost bus released", int'(b), 8'h10);
    check("R8 no mask after loss", mask_cnt - base, 0);
    alert = 1'b0;

    // R10 idle timeout with ACK held
    bus_start;
    for (int i = 7; i >= 0; i--) wbit(logic'(8'h5C >> i));
    sda_h = 1'b1;
    repeat (20) @(negedge clk);
    check("R10 ack held before timeout", int'(sda_oe), 1);
    repeat (TMO - 300) @(negedge clk);
    check("R10 still held near limit", int'(sda_oe), 1);
    repeat (400) @(negedge clk);
    check("R10 released after timeout", int'(sda_oe), 0);
    bus_stop;
    bus_start; send(8'h5D, ack); check("R10 recovered ack", int'(ack), 1);
    recv(b, 8'hFF); bus_stop;
    check("R10 recovered data", int'(b), 8'h55);

    hp;
    check("R2 no pending writes", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule